// File: doc/BRIEF.md
# Asynchronous Parallel Bus Access Sequencer

This block turns single requests from a valid/ready interface into timed accesses on one asynchronous parallel bus with a single chip select. Bus of this kind is typical of panel controllers that carry their own frame memory. Each access has three phases, counted in cycles of the block clock. In the setup phase the bus and control lines settle. In the strobe phase the read or write strobe is low. In the hold phase the lines are kept steady after the strobe rises. Reads and writes each have their own three counts. The counts come from configuration inputs and are captured when a request is accepted.

Between accesses the chip select goes high for a programmable idle gap. One case is different: when a read follows a read, no gap is inserted. A read offered during the last hold cycle of a read is taken at once, so chip select stays low into the next access. Every access ends with a one-cycle done pulse. For a read, that pulse also presents the word sampled from the bus at the end of the strobe.

Top module: `pbus_access_seq`

## Requirements
- R1: While reset is active and after it is released, chip select and both strobes are high. Output enable, direction, address-latch enable and done are low. Ready is high when no request is pending.
- R2: A write accepted at a clock edge holds chip select low for exactly W_SU cycles with both strobes high. The write strobe is then low for W_ST cycles. Chip select then stays low for W_HD cycles with the strobe high. A setup count of 0 puts the strobe in the first chip-select cycle.
- R3: A read follows the same three-phase sequence with the read counts R_SU, R_ST and R_HD, using the read strobe. During the whole read, output enable and direction are low.
- R4: A strobe or hold count programmed as 0 behaves as 1. The strobe always rises with chip select still low.
- R5: During an access, the address-latch enable equals the request's ale bit, and output enable and direction equal the request's write bit. For a write, the data output carries the request's write word. All of these stay unchanged from the first to the last chip-select cycle of the access.
- R6: At the clock edge that ends the last strobe cycle of a read, the word on the data input is captured. In the next cycle, rsp_rdata presents it and rsp_done is high for exactly one cycle. Writes give the same single done pulse and leave rsp_rdata unchanged.
- R7: Unless both accesses are reads, chip select stays high for exactly GAP+1 cycles between two accesses when the next request is already waiting. GAP is the 2-bit gap value captured with the earlier access. Ready stays low for a write during those cycles.
- R8: A read offered during the final hold cycle of a read is accepted at that edge. Its setup or strobe phase follows in the next cycle, with no chip-select-high cycle. A read offered later, while idle after a read, is accepted at once whatever the gap.
- R9: All timing counts are captured when a request is accepted. Changing the configuration inputs during an access does not alter that access.
- R10: Ready is low from the acceptance edge through the end of the hold phase, except in the case of R8. While a gap is pending after a read, ready depends on req_write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all phase counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_setup | input | 5 | Write setup cycles (0 allowed) |
| cfg_wr_strobe | input | 6 | Write strobe cycles (0 treated as 1) |
| cfg_wr_hold | input | 4 | Write hold cycles (0 treated as 1) |
| cfg_rd_setup | input | 5 | Read setup cycles (0 allowed) |
| cfg_rd_strobe | input | 6 | Read strobe cycles (0 treated as 1) |
| cfg_rd_hold | input | 4 | Read hold cycles (0 treated as 1) |
| cfg_gap | input | 2 | Idle gap is this value plus one cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ale | input | 1 | Level driven on the address-latch enable during the access |
| req_wdata | input | DW | Word driven on the bus for a write |
| rsp_done | output | 1 | One-cycle pulse after the strobe of each access |
| rsp_rdata | output | DW | Word captured by the latest read |
| bus_data_o | output | DW | Bus data driven out |
| bus_data_oe | output | 1 | High while the block drives the bus |
| bus_data_i | input | DW | Bus data sampled on reads |
| bus_ale | output | 1 | Address-latch enable |
| bus_dir | output | 1 | Direction, high for a write |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |

## Verification
The bench measures each phase length at the pins. It drives counts of zero for strobe and hold, where a design without the clamp would wrap its counter and stretch the phase to 64 or 16 cycles. It also drives the largest counts, where an off-by-one shows up as one extra or one missing cycle. The bench model changes the read word every strobe cycle, so a design that samples too early returns a smaller value. The gap cases cover write-after-read, read-after-write and two reads both idle and chained. A design that applied the gap to two reads, or skipped it for a write, would show the wrong number of chip-select-high cycles. Finally, the bench changes the configuration in the middle of an access; a design that did not capture its timing would stretch that access.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  localparam int SU_W = 5;
  localparam int ST_W = 6;
  localparam int HD_W = 4;
  localparam int GP_W = 2;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    logic [SU_W-1:0] wr_setup;
    logic [ST_W-1:0] wr_strobe;
    logic [HD_W-1:0] wr_hold;
    logic [SU_W-1:0] rd_setup;
    logic [ST_W-1:0] rd_strobe;
    logic [HD_W-1:0] rd_hold;
    logic [GP_W-1:0] gap;
  } timing_t;

  localparam timing_t TIMING_RST = '{
    wr_setup:  SU_W'(0),
    wr_strobe: ST_W'(2),
    wr_hold:   HD_W'(2),
    rd_setup:  SU_W'(0),
    rd_strobe: ST_W'(1),
    rd_hold:   HD_W'(1),
    gap:       GP_W'(0)
  };

  // strobe and hold phases last at least one cycle
  function automatic timing_t clamp_timing(input timing_t t);
    timing_t c;
    c = t;
    if (t.wr_strobe == '0) c.wr_strobe = ST_W'(1);
    if (t.rd_strobe == '0) c.rd_strobe = ST_W'(1);
    if (t.wr_hold == '0)   c.wr_hold   = HD_W'(1);
    if (t.rd_hold == '0)   c.rd_hold   = HD_W'(1);
    return c;
  endfunction

endpackage

// File: rtl/pbus_rst_sync.sv
module pbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/pbus_timing_reg.sv
module pbus_timing_reg
  import pbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load_en,
  input  timing_t cfg_i,
  output timing_t tim_o
);

  timing_t tim_q;
  timing_t tim_d;

  always_comb begin
    tim_d = tim_q;
    if (load_en) tim_d = cfg_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tim_q <= TIMING_RST;
    else        tim_q <= tim_d;
  end

  assign tim_o = tim_q;

endmodule

// File: rtl/pbus_phase_ctrl.sv
module pbus_phase_ctrl
  import pbus_pkg::*;
#(
  parameter int CW = ST_W
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    req_write,
  input  timing_t cfg_c,
  input  timing_t tim,
  output logic    req_ready,
  output logic    accept,
  output phase_e  phase_o,
  output logic    wr_o,
  output logic    cap_en,
  output logic    done_o
);

  phase_e          phase_q, phase_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [GP_W-1:0] gap_q, gap_d;
  logic            last_rd_q, last_rd_d;
  logic            wr_q, wr_d;
  logic            done_q, done_d;

  logic            hold_last;
  logic            chain_ok;
  logic            idle_ok;
  logic [CW-1:0]   first_su;
  logic [CW-1:0]   first_st;
  logic [CW-1:0]   run_st;
  logic [CW-1:0]   run_hd;

  assign hold_last = (phase_q == PH_HOLD) && (cnt_q == '0);
  assign chain_ok  = hold_last && !wr_q && !req_write;
  assign idle_ok   = (phase_q == PH_IDLE) &&
                     ((gap_q == '0) || (last_rd_q && !req_write));
  assign req_ready = idle_ok || chain_ok;
  assign accept    = req_valid && req_ready;

  assign first_su = req_write ? CW'(cfg_c.wr_setup)  : CW'(cfg_c.rd_setup);
  assign first_st = req_write ? CW'(cfg_c.wr_strobe) : CW'(cfg_c.rd_strobe);
  assign run_st   = wr_q ? CW'(tim.wr_strobe) : CW'(tim.rd_strobe);
  assign run_hd   = wr_q ? CW'(tim.wr_hold)   : CW'(tim.rd_hold);

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    gap_d     = gap_q;
    last_rd_d = last_rd_q;
    wr_d      = wr_q;
    done_d    = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (gap_q != '0) gap_d = gap_q - 1'b1;
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_STROBE;
          cnt_d   = run_st - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_STROBE: begin
        if (cnt_q == '0) begin
          phase_d = PH_HOLD;
          cnt_d   = run_hd - 1'b1;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          phase_d   = PH_IDLE;
          gap_d     = tim.gap;
          last_rd_d = !wr_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
    if (accept) begin
      wr_d  = req_write;
      gap_d = '0;
      if (first_su == '0) begin
        phase_d = PH_STROBE;
        cnt_d   = first_st - 1'b1;
      end else begin
        phase_d = PH_SETUP;
        cnt_d   = first_su - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      gap_q     <= '0;
      last_rd_q <= 1'b0;
      wr_q      <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      cnt_q     <= cnt_d;
      gap_q     <= gap_d;
      last_rd_q <= last_rd_d;
      wr_q      <= wr_d;
      done_q    <= done_d;
    end
  end

  assign phase_o = phase_q;
  assign wr_o    = wr_q;
  assign cap_en  = (phase_q == PH_STROBE) && (cnt_q == '0) && !wr_q;
  assign done_o  = done_q;

  // R6
  done_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (phase_q == PH_HOLD));

  // R7
  gap_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOLD && cnt_q == '0 && tim.gap != '0 && req_write) |=> !req_ready);

endmodule

// File: rtl/pbus_bus_drv.sv
module pbus_bus_drv
  import pbus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          req_ale,
  input  logic [DW-1:0] req_wdata,
  input  phase_e        phase,
  input  logic          wr,
  input  logic          cap_en,
  input  logic [DW-1:0] bus_data_i,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_data_oe,
  output logic          bus_ale,
  output logic          bus_dir,
  output logic          bus_cs_n,
  output logic          bus_wr_n,
  output logic          bus_rd_n,
  output logic [DW-1:0] rdata
);

  logic          ale_q, ale_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          active;
  logic          in_strobe;

  always_comb begin
    ale_d   = ale_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    if (accept) begin
      ale_d   = req_ale;
      wdata_d = req_wdata;
    end
    if (cap_en) rdata_d = bus_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q   <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      ale_q   <= ale_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

  assign active      = (phase != PH_IDLE);
  assign in_strobe   = (phase == PH_STROBE);
  assign bus_cs_n    = !active;
  assign bus_ale     = active && ale_q;
  assign bus_dir     = active && wr;
  assign bus_data_oe = active && wr;
  assign bus_data_o  = (active && wr) ? wdata_q : '0;
  assign bus_wr_n    = !(in_strobe && wr);
  assign bus_rd_n    = !(in_strobe && !wr);
  assign rdata       = rdata_q;

  // R5
  wr_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n) && bus_dir && $past(bus_dir)) |-> $stable(bus_data_o));

  // R3
  rd_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> (!bus_data_oe && !bus_dir));

endmodule

// File: rtl/pbus_access_seq.sv
module pbus_access_seq
  import pbus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SU_W-1:0] cfg_wr_setup,
  input  logic [ST_W-1:0] cfg_wr_strobe,
  input  logic [HD_W-1:0] cfg_wr_hold,
  input  logic [SU_W-1:0] cfg_rd_setup,
  input  logic [ST_W-1:0] cfg_rd_strobe,
  input  logic [HD_W-1:0] cfg_rd_hold,
  input  logic [GP_W-1:0] cfg_gap,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic            req_ale,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_done,
  output logic [DW-1:0]   rsp_rdata,
  output logic [DW-1:0]   bus_data_o,
  output logic            bus_data_oe,
  input  logic [DW-1:0]   bus_data_i,
  output logic            bus_ale,
  output logic            bus_dir,
  output logic            bus_cs_n,
  output logic            bus_wr_n,
  output logic            bus_rd_n
);

  localparam int CW = (ST_W > SU_W) ? ST_W : SU_W;

  logic    srst_n;
  timing_t cfg_raw;
  timing_t cfg_c;
  timing_t tim;
  logic    accept;
  phase_e  phase;
  logic    wr;
  logic    cap_en;

  assign cfg_raw = '{
    wr_setup:  cfg_wr_setup,
    wr_strobe: cfg_wr_strobe,
    wr_hold:   cfg_wr_hold,
    rd_setup:  cfg_rd_setup,
    rd_strobe: cfg_rd_strobe,
    rd_hold:   cfg_rd_hold,
    gap:       cfg_gap
  };
  assign cfg_c = clamp_timing(cfg_raw);

  pbus_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (srst_n)
  );

  pbus_timing_reg timing_i (
    .clk     (clk),
    .rst_n   (srst_n),
    .load_en (accept),
    .cfg_i   (cfg_c),
    .tim_o   (tim)
  );

  pbus_phase_ctrl #(.CW(CW)) ctrl_i (
    .clk       (clk),
    .rst_n     (srst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .cfg_c     (cfg_c),
    .tim       (tim),
    .req_ready (req_ready),
    .accept    (accept),
    .phase_o   (phase),
    .wr_o      (wr),
    .cap_en    (cap_en),
    .done_o    (rsp_done)
  );

  pbus_bus_drv #(.DW(DW)) drv_i (
    .clk         (clk),
    .rst_n       (srst_n),
    .accept      (accept),
    .req_ale     (req_ale),
    .req_wdata   (req_wdata),
    .phase       (phase),
    .wr          (wr),
    .cap_en      (cap_en),
    .bus_data_i  (bus_data_i),
    .bus_data_o  (bus_data_o),
    .bus_data_oe (bus_data_oe),
    .bus_ale     (bus_ale),
    .bus_dir     (bus_dir),
    .bus_cs_n    (bus_cs_n),
    .bus_wr_n    (bus_wr_n),
    .bus_rd_n    (bus_rd_n),
    .rdata       (rsp_rdata)
  );

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rsp_done |=> !rsp_done);

  // R6
  rdata_on_done_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !$stable(rsp_rdata) |-> rsp_done);

  // R10
  ready_low_strobe_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!bus_wr_n || !bus_rd_n) |-> !req_ready);

  // R4
  wr_hold_min_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(bus_wr_n) |-> !bus_cs_n);

  // R4
  rd_hold_min_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(bus_rd_n) |-> !bus_cs_n);

  // R2
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!bus_wr_n || !bus_rd_n) |-> !bus_cs_n);

endmodule

// File: tb/pbus_access_seq_tb_top.sv
module pbus_access_seq_tb_top;

  localparam int DW = 8;
  localparam int NV = 8;
  localparam int MAXA = 64;

  typedef struct packed {
    logic       wr;
    logic       ale;
    logic [7:0] d;
    logic [4:0] ws;
    logic [5:0] wd;
    logic [3:0] wh;
    logic [4:0] rs;
    logic [5:0] rd;
    logic [3:0] rh;
    logic [1:0] gp;
  } vec_t;

  // wr ale data ws wd wh rs rd rh gap
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 8'hA5, 5'd0,  6'd2,  4'd2,  5'd0,  6'd1,  4'd1,  2'd0},
    '{1'b0, 1'b0, 8'h3C, 5'd0,  6'd2,  4'd2,  5'd3,  6'd4,  4'd2,  2'd2},
    '{1'b1, 1'b0, 8'h5A, 5'd2,  6'd0,  4'd0,  5'd3,  6'd4,  4'd2,  2'd3},
    '{1'b0, 1'b1, 8'hF0, 5'd2,  6'd0,  4'd0,  5'd0,  6'd0,  4'd0,  2'd1},
    '{1'b0, 1'b0, 8'h10, 5'd2,  6'd0,  4'd0,  5'd31, 6'd63, 4'd15, 2'd0},
    '{1'b1, 1'b1, 8'hFF, 5'd31, 6'd63, 4'd15, 5'd0,  6'd1,  4'd1,  2'd2},
    '{1'b1, 1'b0, 8'h00, 5'd1,  6'd1,  4'd1,  5'd0,  6'd1,  4'd1,  2'd0},
    '{1'b0, 1'b1, 8'h80, 5'd1,  6'd1,  4'd1,  5'd0,  6'd2,  4'd3,  2'd1}
  };

  logic          clk;
  logic          rst_n;
  logic [4:0]    cfg_wr_setup, cfg_rd_setup;
  logic [5:0]    cfg_wr_strobe, cfg_rd_strobe;
  logic [3:0]    cfg_wr_hold, cfg_rd_hold;
  logic [1:0]    cfg_gap;
  logic          req_valid, req_ready, req_write, req_ale;
  logic [DW-1:0] req_wdata;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [DW-1:0] bus_data_o, bus_data_i;
  logic          bus_data_oe, bus_ale, bus_dir, bus_cs_n, bus_wr_n, bus_rd_n;

  int n_chk;
  int n_fail;

  // bench bus model and monitor state
  logic [DW-1:0] dev_val;
  int  acc_n, done_n;
  int  m_setup, m_strobe, m_hold, m_idle, m_gap;
  bit  m_in, m_seen, m_bad;
  logic m_dir, m_ale, m_oe;
  logic [DW-1:0] m_dout;
  int  r_setup [MAXA];
  int  r_strobe [MAXA];
  int  r_hold [MAXA];
  int  r_gap [MAXA];
  bit  r_bad [MAXA];
  logic r_dir [MAXA];
  logic r_ale [MAXA];
  logic r_oe [MAXA];
  logic [DW-1:0] r_dout [MAXA];
  logic [DW-1:0] done_data [MAXA];

  assign bus_data_i = dev_val + DW'(m_strobe);

  pbus_access_seq #(.DW(DW)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr_setup  (cfg_wr_setup),
    .cfg_wr_strobe (cfg_wr_strobe),
    .cfg_wr_hold   (cfg_wr_hold),
    .cfg_rd_setup  (cfg_rd_setup),
    .cfg_rd_strobe (cfg_rd_strobe),
    .cfg_rd_hold   (cfg_rd_hold),
    .cfg_gap       (cfg_gap),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_ale       (req_ale),
    .req_wdata     (req_wdata),
    .rsp_done      (rsp_done),
    .rsp_rdata     (rsp_rdata),
    .bus_data_o    (bus_data_o),
    .bus_data_oe   (bus_data_oe),
    .bus_data_i    (bus_data_i),
    .bus_ale       (bus_ale),
    .bus_dir       (bus_dir),
    .bus_cs_n      (bus_cs_n),
    .bus_wr_n      (bus_wr_n),
    .bus_rd_n      (bus_rd_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    bit strobe;
    if (!rst_n) begin
      acc_n = 0; done_n = 0; m_in = 0; m_seen = 0; m_bad = 0;
      m_setup = 0; m_strobe = 0; m_hold = 0; m_idle = 0; m_gap = 0;
    end else begin
      strobe = !bus_wr_n || !bus_rd_n;
      if (m_in && (bus_cs_n || (strobe && m_hold > 0))) begin
        if (acc_n < MAXA) begin
          r_setup[acc_n] = m_setup; r_strobe[acc_n] = m_strobe;
          r_hold[acc_n] = m_hold; r_gap[acc_n] = m_gap; r_bad[acc_n] = m_bad;
          r_dir[acc_n] = m_dir; r_ale[acc_n] = m_ale; r_oe[acc_n] = m_oe;
          r_dout[acc_n] = m_dout;
        end
        acc_n = acc_n + 1;
        m_in = 0;
      end
      if (!bus_cs_n && !m_in) begin
        m_in = 1; m_seen = 0; m_bad = 0;
        m_setup = 0; m_strobe = 0; m_hold = 0;
        m_gap = m_idle; m_idle = 0;
        m_dir = bus_dir; m_ale = bus_ale; m_oe = bus_data_oe; m_dout = bus_data_o;
      end
      if (m_in) begin
        if (strobe) begin m_strobe = m_strobe + 1; m_seen = 1; end
        else if (m_seen) m_hold = m_hold + 1;
        else m_setup = m_setup + 1;
        if (bus_dir !== m_dir || bus_ale !== m_ale ||
            bus_data_oe !== m_oe || bus_data_o !== m_dout) m_bad = 1;
      end
      if (bus_cs_n) m_idle = m_idle + 1;
      if (rsp_done) begin
        if (done_n < MAXA) done_data[done_n] = rsp_rdata;
        done_n = done_n + 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input vec_t v);
    cfg_wr_setup = v.ws; cfg_wr_strobe = v.wd; cfg_wr_hold = v.wh;
    cfg_rd_setup = v.rs; cfg_rd_strobe = v.rd; cfg_rd_hold = v.rh;
    cfg_gap = v.gp;
  endtask

  task automatic issue(input logic wr, input logic ale, input logic [DW-1:0] d);
    req_write = wr; req_ale = ale; req_wdata = d; req_valid = 1'b1;
    forever begin
      #1;
      if (req_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1 req_valid = 1'b0;
  endtask

  function automatic int at_least1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  initial begin
    #(20 * 20000);
    n_fail = n_fail + 1;
    $display("FAIL watchdog: actual %0d expected %0d accesses", acc_n, acc_n + 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] last_rd;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_ale = 1'b0;
    req_wdata = '0; dev_val = '0;
    set_cfg(VECS[0]);
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "cs_n in reset", int'(bus_cs_n), 1);
    chk("R1", "wr_n in reset", int'(bus_wr_n), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 after release
    chk("R1", "cs_n", int'(bus_cs_n), 1);
    chk("R1", "rd_n", int'(bus_rd_n), 1);
    chk("R1", "oe|dir|ale", int'(bus_data_oe | bus_dir | bus_ale), 0);
    chk("R1", "done", int'(rsp_done), 0);
    chk("R1", "ready", int'(req_ready), 1);
    @(negedge clk);

    // table of vectors, one access each
    last_rd = '0;
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int es, et, eh, eg;
      v = VECS[i];
      set_cfg(v);
      dev_val = v.d;
      issue(v.wr, v.ale, v.d);
      wait (acc_n >= i + 1);
      es = v.wr ? int'(v.ws) : int'(v.rs);
      et = at_least1(v.wr ? int'(v.wd) : int'(v.rd));
      eh = at_least1(v.wr ? int'(v.wh) : int'(v.rh));
      // R2 R3 R4 phase lengths
      chk(v.wr ? "R2" : "R3", "setup", r_setup[i], es);
      chk(v.wr ? "R2" : "R3", "strobe", r_strobe[i], et);
      chk("R4", "hold", r_hold[i], eh);
      // R5 control and data levels
      chk("R5", "dir", int'(r_dir[i]), int'(v.wr));
      chk("R5", "oe", int'(r_oe[i]), int'(v.wr));
      chk("R5", "ale", int'(r_ale[i]), int'(v.ale));
      chk("R5", "dout", int'(r_dout[i]), v.wr ? int'(v.d) : 0);
      chk("R5", "stable", int'(r_bad[i]), 0);
      // R6 done and read data
      chk("R6", "done count", done_n, i + 1);
      if (!v.wr) last_rd = v.d + DW'(et);
      chk("R6", "rdata", int'(done_data[i]), int'(last_rd));
      if (i > 0) begin
        eg = (!VECS[i-1].wr && !v.wr) ? 1 : int'(VECS[i-1].gp) + 1;
        // R7 R8 idle gap
        chk((!VECS[i-1].wr && !v.wr) ? "R8" : "R7", "gap", r_gap[i], eg);
      end
    end

    // R8 chained reads: second read taken in final hold cycle
    begin
      vec_t c;
      int base;
      c = '{1'b0, 1'b0, 8'h20, 5'd0, 6'd1, 4'd1, 5'd0, 6'd2, 4'd1, 2'd3};
      set_cfg(c);
      dev_val = 8'h20;
      base = acc_n;
      issue(1'b0, 1'b0, 8'h00);
      issue(1'b0, 1'b1, 8'h00);
      wait (acc_n >= base + 2);
      chk("R8", "chain gap", r_gap[base+1], 0);
      chk("R8", "first hold", r_hold[base], 1);
      chk("R8", "second strobe", r_strobe[base+1], 2);
      chk("R8", "second ale", int'(r_ale[base+1]), 1);
      chk("R6", "chain rdata 1", int'(done_data[base]), 8'h22);
      chk("R6", "chain rdata 2", int'(done_data[base+1]), 8'h22);
      // R10 gap pending after read: ready depends on req_write
      req_valid = 1'b0;
      req_write = 1'b1;
      #1 chk("R10", "ready for write in gap", int'(req_ready), 0);
      req_write = 1'b0;
      #1 chk("R10", "ready for read in gap", int'(req_ready), 1);
    end

    // R9 timing captured at acceptance
    begin
      vec_t a, b;
      int base;
      a = '{1'b1, 1'b1, 8'h69, 5'd2, 6'd3, 4'd2, 5'd0, 6'd1, 4'd1, 2'd0};
      b = '{1'b1, 1'b1, 8'h69, 5'd9, 6'd9, 4'd9, 5'd9, 6'd9, 4'd9, 2'd3};
      set_cfg(a);
      base = acc_n;
      issue(1'b1, 1'b1, 8'h69);
      set_cfg(b);
      req_write = 1'b1;
      @(negedge clk);
      #1 chk("R10", "ready during access", int'(req_ready), 0);
      wait (acc_n >= base + 1);
      chk("R7", "write after read gap", r_gap[base], 4);
      chk("R9", "setup", r_setup[base], 2);
      chk("R9", "strobe", r_strobe[base], 3);
      chk("R9", "hold", r_hold[base], 2);
      chk("R6", "write keeps rdata", int'(done_data[base]), 8'h22);
    end

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule